// File: doc/BRIEF.md
# Binary-Coded-Modulation LED Matrix Row Scanner

The scanner turns a packed stream of 32-bit words into the drive signals of a multiplexed RGB LED matrix. The stream is a series of fixed 60-byte sub-frame records. Each record says how many pixels to shift and what colour bits each pixel has. It also gives the row the data belongs to and how long that row stays lit. The block shifts the colour bits into the column driver chain on three serial lines with a column clock. It then pulses the latch and presents the row address. Finally it releases the blank line for a number of prescaled ticks. Binary-coded modulation comes from the stream itself: an upstream producer writes sub-frame f of a row with an on-time of 2^f ticks, and 14 such sub-frames per row make up 14-bit intensity.

Words enter through a valid/ready handshake and are consumed least significant byte first. Record fields sit at fixed byte positions:

| Byte | Content |
|---|---|
| 0 | pixel count minus one |
| 1–53 | pixel slots |
| 54–55 | filler |
| 56 | row number in bits 3:0 |
| 57–59 | on-time, low byte first |

The block reads every one of these fields in-band and holds no row or weight counter of its own. When a record ends, the next word is taken as the start of a new record, so a producer that replays its buffer makes the display loop.

The controller is a state machine with these states:

| State | Action | Leaves for |
|---|---|---|
| S_COUNT | takes the count byte | S_PIXEL |
| S_PIXEL | takes one pixel slot | S_SETUP if the slot is live; after the last slot, S_SKIP |
| S_SETUP | data lines settle, clock low | S_CLK |
| S_CLK | clock high for one cycle | S_PIXEL, or S_SKIP after the last slot |
| S_SKIP | discards filler | S_ROW |
| S_ROW | captures the row byte | S_TICK |
| S_TICK | shifts in three on-time bytes; the last one also moves the captured row onto the address lines | S_LATCH |
| S_LATCH | one-cycle latch pulse | S_HOLD, or S_COUNT when the on-time is zero |
| S_HOLD | blank released | S_COUNT when the last tick ends |

Top module: `bcm_row_scanner`

## Requirements
- R1: After reset, blank is 1, col_clk and col_latch are 0, row_addr is 0 and in_ready is 1.
- R2: The four bytes of each accepted word are used lowest byte (bits 7:0) first, and a record continues across word boundaries with no gap or realignment.
- R3: For each shifted pixel, col_r carries bit 0 of its byte, col_g bit 1 and col_b bit 2. Bits 7:3 have no effect on any output.
- R4: With byte 0 equal to N, exactly min(N+1, 53) col_clk pulses are produced, one per pixel slot, in slot order. Slots beyond that count and the two filler bytes produce no pulse.
- R5: After the on-time bytes of each record, col_latch is high for exactly one cycle, including records with zero on-time.
- R6: row_addr takes bits 3:0 of byte 56; bits 7:4 are ignored. row_addr changes only while blank is 1, and its new value is present in the latch cycle.
- R7: The on-time T is the 24-bit value of bytes 57 (bits 7:0), 58 (bits 15:8) and 59 (bits 23:16). Blank goes low for exactly T × PRESCALE consecutive cycles. With T = 0, blank stays high.
- R8: in_ready is 0 in every cycle where blank is 0.
- R9: col_clk is high for single cycles only, and col_r/col_g/col_b do not change in a cycle where col_clk is high.
- R10: A row's 14 sub-frames with on-times 2^0 to 2^13 give blank-low windows of exactly 2^f × PRESCALE cycles, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| in_word | input | 32 | packed stream word |
| in_valid | input | 1 | in_word holds a word |
| in_ready | output | 1 | word accepted on this edge when in_valid is 1 |
| col_clk | output | 1 | column chain shift clock |
| col_r | output | 1 | red serial data |
| col_g | output | 1 | green serial data |
| col_b | output | 1 | blue serial data |
| col_latch | output | 1 | column chain latch pulse |
| blank | output | 1 | 1 = outputs off |
| row_addr | output | 4 | selected row |

## Verification
The scanner is fed records of several kinds:
- A short record whose unused slots hold non-zero junk. This separates a correct pixel-count decode from one that clocks every slot.
- A full 53-pixel record, which exercises the last-slot exit from S_CLK into S_SKIP.
- A count byte above 53, which must saturate at the slot limit.
- A zero on-time record, which must latch without ever dropping blank.
- An on-time of 258, which has a non-zero middle byte and so exposes any error in byte order.
- A full 14-sub-frame row with weights 2^0 to 2^13, which checks that each window length follows its record.

Every pixel byte carries random upper bits. The row bytes carry junk in bits 7:4, so masking errors show up as wrong colour or address values.

// File: rtl/bcm_scan_pkg.sv
package bcm_scan_pkg;

    typedef enum logic [3:0] {
        S_COUNT,
        S_PIXEL,
        S_SETUP,
        S_CLK,
        S_SKIP,
        S_ROW,
        S_TICK,
        S_LATCH,
        S_HOLD
    } scan_state_t;

endpackage

// File: rtl/bcm_word_unpacker.sv
module bcm_word_unpacker #(
    parameter int WORD_BYTES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [8*WORD_BYTES-1:0]   in_word,
    input  logic                      in_valid,
    input  logic                      accept_en,
    output logic                      in_ready,
    output logic [7:0]                byte_data,
    output logic                      byte_valid,
    input  logic                      byte_take
);
    localparam int WW = 8 * WORD_BYTES;
    localparam int CW = $clog2(WORD_BYTES + 1);

    logic [WW-1:0] word_q;
    logic [CW-1:0] left_q;

    assign byte_valid = (left_q != '0);
    assign byte_data  = word_q[7:0];
    assign in_ready   = accept_en && ((left_q == '0) || ((left_q == CW'(1)) && byte_take));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            left_q <= '0;
        end else if (in_valid && in_ready) begin
            word_q <= in_word;
            left_q <= CW'(WORD_BYTES);
        end else if (byte_take) begin
            word_q <= word_q >> 8;
            left_q <= left_q - CW'(1);
        end
    end

    // R2: the controller never pulls a byte that is not there
    a_r2_take_has_byte: assert property (@(posedge clk) disable iff (!rst_n)
        byte_take |-> byte_valid);

endmodule

// File: rtl/bcm_hold_timer.sv
module bcm_hold_timer #(
    parameter int TICK_W   = 24,
    parameter int PRESCALE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [TICK_W-1:0] load_val,
    input  logic              run,
    output logic              done
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    logic [PW-1:0]     pre_q;
    logic [TICK_W-1:0] left_q;
    logic              strobe;

    assign strobe = run && (pre_q == PW'(PRESCALE - 1));
    assign done   = strobe && (left_q == TICK_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run || strobe) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= load_val;
        end else if (strobe) begin
            left_q <= left_q - TICK_W'(1);
        end
    end

    // R7: a tick is never counted past zero
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> (left_q != '0));

endmodule

// File: rtl/bcm_record_fsm.sv
module bcm_record_fsm
    import bcm_scan_pkg::*;
#(
    parameter int PIX_SLOTS  = 53,
    parameter int PAD_BYTES  = 2,
    parameter int ROW_BITS   = 4,
    parameter int TICK_BYTES = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [7:0]              byte_data,
    input  logic                    byte_valid,
    output logic                    byte_take,
    output logic                    timer_load,
    output logic [8*TICK_BYTES-1:0] timer_val,
    output logic                    timer_run,
    input  logic                    hold_done,
    output logic                    col_clk,
    output logic                    col_r,
    output logic                    col_g,
    output logic                    col_b,
    output logic                    col_latch,
    output logic                    blank,
    output logic [ROW_BITS-1:0]     row_addr
);
    localparam int TW        = 8 * TICK_BYTES;
    localparam int PIX_LAST  = PIX_SLOTS;
    localparam int PAD_LAST  = PIX_SLOTS + PAD_BYTES;
    localparam int ROW_IDX   = PAD_LAST + 1;
    localparam int TICK_LAST = ROW_IDX + TICK_BYTES;
    localparam int REC_BYTES = TICK_LAST + 1;
    localparam int IDXW      = $clog2(REC_BYTES + 1);

    scan_state_t         state_q, state_d, after_pix;
    logic [IDXW-1:0]     idx_q;
    logic [7:0]          cnt_q;
    logic [2:0]          rgb_q;
    logic [ROW_BITS-1:0] row_next_q, row_q;
    logic [TW-1:0]       tick_q;
    logic                pix_live;

    assign after_pix = (PAD_BYTES > 0) ? S_SKIP : S_ROW;
    assign pix_live  = (int'(idx_q) - 1) <= int'(cnt_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_COUNT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_COUNT: if (byte_valid) state_d = S_PIXEL;
            S_PIXEL: if (byte_valid) begin
                if (pix_live)                         state_d = S_SETUP;
                else if (idx_q == IDXW'(PIX_LAST))    state_d = after_pix;
            end
            S_SETUP: state_d = S_CLK;
            S_CLK:   state_d = (idx_q == IDXW'(PIX_LAST + 1)) ? after_pix : S_PIXEL;
            S_SKIP:  if (byte_valid && idx_q == IDXW'(PAD_LAST)) state_d = S_ROW;
            S_ROW:   if (byte_valid) state_d = S_TICK;
            S_TICK:  if (byte_valid && idx_q == IDXW'(TICK_LAST)) state_d = S_LATCH;
            S_LATCH: state_d = (tick_q == '0) ? S_COUNT : S_HOLD;
            S_HOLD:  if (hold_done) state_d = S_COUNT;
            default: state_d = S_COUNT;
        endcase
    end

    always_comb begin
        unique case (state_q)
            S_COUNT, S_PIXEL, S_SKIP, S_ROW, S_TICK: byte_take = byte_valid;
            default:                                  byte_take = 1'b0;
        endcase
    end

    // field capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q      <= '0;
            cnt_q      <= '0;
            rgb_q      <= '0;
            row_next_q <= '0;
            row_q      <= '0;
            tick_q     <= '0;
        end else begin
            if (state_q == S_LATCH) begin
                idx_q <= '0;
            end else if (byte_take) begin
                idx_q <= idx_q + IDXW'(1);
            end
            if (byte_take) begin
                unique case (state_q)
                    S_COUNT: cnt_q <= byte_data;
                    S_PIXEL: if (pix_live) rgb_q <= byte_data[2:0];
                    S_ROW:   row_next_q <= byte_data[ROW_BITS-1:0];
                    S_TICK: begin
                        tick_q <= (tick_q >> 8) | (TW'(byte_data) << (TW - 8));
                        if (idx_q == IDXW'(TICK_LAST)) row_q <= row_next_q;
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        col_clk    = (state_q == S_CLK);
        col_latch  = (state_q == S_LATCH);
        blank      = (state_q != S_HOLD);
        timer_load = (state_q == S_LATCH);
        timer_run  = (state_q == S_HOLD);
        timer_val  = tick_q;
        col_r      = rgb_q[0];
        col_g      = rgb_q[1];
        col_b      = rgb_q[2];
        row_addr   = row_q;
    end

    // R9: shift clock pulses are one cycle wide
    a_r9_clk_single: assert property (@(posedge clk) disable iff (!rst_n)
        col_clk |=> !col_clk);
    // R9: data held while the clock is high
    a_r9_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        col_clk |-> $stable({col_b, col_g, col_r}));
    // R5: latch pulse lasts one cycle
    a_r5_latch_single: assert property (@(posedge clk) disable iff (!rst_n)
        col_latch |=> !col_latch);
    // R6: row address moves only while blanked
    a_r6_row_blanked: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(row_addr) |-> blank);

endmodule

// File: rtl/bcm_row_scanner.sv
module bcm_row_scanner #(
    parameter int WORD_BYTES = 4,
    parameter int PIX_SLOTS  = 53,
    parameter int PAD_BYTES  = 2,
    parameter int ROW_BITS   = 4,
    parameter int TICK_BYTES = 3,
    parameter int PRESCALE   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [8*WORD_BYTES-1:0] in_word,
    input  logic                    in_valid,
    output logic                    in_ready,
    output logic                    col_clk,
    output logic                    col_r,
    output logic                    col_g,
    output logic                    col_b,
    output logic                    col_latch,
    output logic                    blank,
    output logic [ROW_BITS-1:0]     row_addr
);
    localparam int TW = 8 * TICK_BYTES;

    logic [7:0]    byte_data;
    logic          byte_valid, byte_take;
    logic          timer_load, timer_run, hold_done;
    logic [TW-1:0] timer_val;

    bcm_word_unpacker #(.WORD_BYTES(WORD_BYTES)) u_unpack (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_word    (in_word),
        .in_valid   (in_valid),
        .accept_en  (!timer_run),
        .in_ready   (in_ready),
        .byte_data  (byte_data),
        .byte_valid (byte_valid),
        .byte_take  (byte_take)
    );

    bcm_record_fsm #(
        .PIX_SLOTS  (PIX_SLOTS),
        .PAD_BYTES  (PAD_BYTES),
        .ROW_BITS   (ROW_BITS),
        .TICK_BYTES (TICK_BYTES)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_data  (byte_data),
        .byte_valid (byte_valid),
        .byte_take  (byte_take),
        .timer_load (timer_load),
        .timer_val  (timer_val),
        .timer_run  (timer_run),
        .hold_done  (hold_done),
        .col_clk    (col_clk),
        .col_r      (col_r),
        .col_g      (col_g),
        .col_b      (col_b),
        .col_latch  (col_latch),
        .blank      (blank),
        .row_addr   (row_addr)
    );

    bcm_hold_timer #(.TICK_W(TW), .PRESCALE(PRESCALE)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .run      (timer_run),
        .done     (hold_done)
    );

    // R8: no word is accepted during a lit window
    a_r8_ready_low_lit: assert property (@(posedge clk) disable iff (!rst_n)
        !blank |-> !in_ready);

endmodule

// File: tb/bcm_row_scanner_bench.sv
module bcm_row_scanner_bench;
    localparam int P = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [31:0] in_word = '0;
    logic in_valid = 1'b0;
    logic in_ready, col_clk, col_r, col_g, col_b, col_latch, blank;
    logic [3:0] row_addr;

    always #5 clk = ~clk;

    bcm_row_scanner u_bcm_row_scanner (
        .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_valid(in_valid),
        .in_ready(in_ready), .col_clk(col_clk), .col_r(col_r), .col_g(col_g),
        .col_b(col_b), .col_latch(col_latch), .blank(blank), .row_addr(row_addr)
    );

    localparam int K_PIX = 0, K_LAT = 1, K_WIN = 2;
    typedef struct { int kind; int val; int len; } exp_t;
    exp_t q[$];

    int checks = 0, fails = 0;
    bit mon_on = 0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic send_word(input logic [31:0] w);
        in_word = w; in_valid = 1'b1;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    // builds one record, queues its expected events, streams it
    task automatic send_record(input int cnt_b, input int seed, input int row, input int tick);
        logic [7:0] rec [60];
        int npix;
        exp_t e;
        rec[0] = 8'(cnt_b);
        for (int i = 1; i <= 53; i++) rec[i] = 8'(seed + i * 29) | 8'h08;
        rec[54] = 8'hFF; rec[55] = 8'h5A;
        rec[56] = 8'(row) | 8'hA0;
        rec[57] = 8'(tick); rec[58] = 8'(tick >> 8); rec[59] = 8'(tick >> 16);
        npix = (cnt_b + 1 > 53) ? 53 : cnt_b + 1;
        for (int p = 0; p < npix; p++) begin
            e.kind = K_PIX; e.val = int'(rec[p + 1] & 8'h07); e.len = 0; q.push_back(e);
        end
        e.kind = K_LAT; e.val = row & 15; e.len = 0; q.push_back(e);
        if (tick != 0) begin
            e.kind = K_WIN; e.val = row & 15; e.len = tick * P; q.push_back(e);
        end
        for (int k = 0; k < 15; k++)
            send_word({rec[4*k+3], rec[4*k+2], rec[4*k+1], rec[4*k]});
    endtask

    // monitor / scoreboard
    logic pclk = 0, plat = 0, pblank = 1;
    int lowcnt = 0;
    bit rdy_bad = 0;
    always @(negedge clk) begin
        if (mon_on) begin
            exp_t e;
            if (col_clk && !pclk) begin
                if (q.size() == 0) check(0, "R4 extra clock", 1, 0);
                else begin
                    e = q.pop_front();
                    check(e.kind == K_PIX, "R4 clock order", e.kind, K_PIX);
                    check({col_b, col_g, col_r} == 3'(e.val), "R3/R2 pixel bits",
                          int'({col_b, col_g, col_r}), e.val);
                end
            end
            if (col_latch && !plat) begin
                if (q.size() == 0) check(0, "R5 extra latch", 1, 0);
                else begin
                    e = q.pop_front();
                    check(e.kind == K_LAT, "R4/R5 latch position", e.kind, K_LAT);
                    check(row_addr == 4'(e.val), "R6 row in latch cycle", int'(row_addr), e.val);
                end
            end
            if (!blank) begin
                lowcnt++;
                if (in_ready) rdy_bad = 1;
            end
            if (blank && !pblank) begin
                if (q.size() == 0) check(0, "R7 extra window", lowcnt, 0);
                else begin
                    e = q.pop_front();
                    check(e.kind == K_WIN, "R7 window position", e.kind, K_WIN);
                    check(lowcnt == e.len, "R7/R10 window length", lowcnt, e.len);
                    check(!rdy_bad, "R8 ready low while lit", int'(rdy_bad), 0);
                end
                lowcnt = 0; rdy_bad = 0;
            end
            if (!blank && (row_addr !== 4'(q.size() > 0 ? q[0].val : row_addr)))
                check(0, "R6 row during window", int'(row_addr), q[0].val);
        end
        pclk = col_clk; plat = col_latch; pblank = blank;
    end

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1 reset state
        check(blank == 1'b1, "R1 blank", int'(blank), 1);
        check(col_clk == 1'b0, "R1 col_clk", int'(col_clk), 0);
        check(col_latch == 1'b0, "R1 col_latch", int'(col_latch), 0);
        check(row_addr == 4'd0, "R1 row_addr", int'(row_addr), 0);
        check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        mon_on = 1;

        send_record(4, 8'h13, 3, 3);      // R4 short record, junk in unused slots
        send_record(52, 8'h71, 10, 1);    // R4 all 53 slots
        send_record(0, 8'h05, 7, 0);      // R5/R7 zero on-time
        send_record(2, 8'h44, 9, 5);
        send_record(200, 8'hC2, 12, 258); // R4 saturation, R7 byte order
        for (int f = 0; f < 14; f++)      // R10 binary weights
            send_record(2, f * 11, 5, 1 << f);

        while (q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        check(q.size() == 0, "R2 all events seen", q.size(), 0);
        check(blank == 1'b1, "R7 blank after last window", int'(blank), 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule